// File: doc/BRIEF.md
# Band-selectable multimodulus prescaler

This block divides a fast input clock by 32, 33, 47 or 48. A small dual-ratio core ends each of its cycles after either two or three input clocks. A four-bit chain counts sixteen core cycles to make one output period. One input chooses the band (the 32/33 pair or the 47/48 pair). A second input chooses the smaller or larger ratio within that pair.

The ratio is steered through one signal, the core mode, which is high for a two-clock core cycle. A NAND gate raises a single "swallow" event on the last core cycle of the chain. In the lower band the NAND output drives the core mode directly. In the upper band a multiplexer passes the inverted NAND output instead. That inversion reverses the roles of two- and three-clock cycles, so the 47/48 pair needs no extra state. Both control inputs are captured only when an output period ends. A ratio change therefore always takes effect on a whole period.

Top module: `mmp_divider`

## Requirements
- R1: A synchronous active-low reset clears the core phase, the chain and the captured controls. `clk_div` is low on the first rising edge of `clk_in` taken with `rst_n` low, and stays low while reset is held, including when reset is applied while `clk_div` is high.
- R2: With `band_hi`=0 and `ratio_small`=1 captured, one output period lasts 32 input cycles.
- R3: With `band_hi`=0 and `ratio_small`=0 captured, one output period lasts 33 input cycles.
- R4: With `band_hi`=1 and `ratio_small`=1 captured, one output period lasts 47 input cycles.
- R5: With `band_hi`=1 and `ratio_small`=0 captured, one output period lasts 48 input cycles.
- R6: `clk_div` is the most significant bit of the 16-state chain. An output period runs from one falling edge of `clk_div` to the next. `clk_div` is high for the last 8 core cycles of the period, which gives high times of 16, 17, 23 and 24 input cycles for the ratios 32, 33, 47 and 48.
- R7: `band_hi` and `ratio_small` are captured only on the input edge where `clk_div` falls. When the inputs change during a period, that period keeps its old ratio and the following period uses the new one.
- R8: After reset is released, the first period (from release to the first falling edge of `clk_div`) lasts 33 input cycles with a 17-cycle high time, whatever the control inputs are.
- R9: Every core cycle except the last one of a period lasts 2 input cycles in the lower band and 3 in the upper band. The low time of `clk_div` is therefore 16 or 24 input cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| band_hi | input | 1 | 0 selects the 32/33 pair, 1 selects the 47/48 pair |
| ratio_small | input | 1 | 1 selects the smaller ratio of the pair, 0 the larger |
| clk_div | output | 1 | Divided clock |

## Verification
Each period length and high time can be seen only over a whole output period. The bench therefore counts input cycles at falling clock edges between consecutive falling edges of `clk_div`, and counts the high cycles within the same window. A control change made just after a falling edge is due to show in the second measured period, not the first. The bench checks the old ratio in the first period and the new ratio in the second, for all sixteen ordered pairs of settings. Reset is due on the next rising edge, so `clk_div` is sampled low at the falling edge that follows that edge.

// File: rtl/mmp_pkg.sv
// Shared definitions for the band-selectable multimodulus prescaler.
// Assumes a single input clock domain; nothing here holds state.
package mmp_pkg;

    // Phase of the dual-ratio core: first, second and optional third input clock.
    typedef enum logic [1:0] {
        PH_FIRST  = 2'd0,
        PH_SECOND = 2'd1,
        PH_THIRD  = 2'd2
    } core_ph_t;

    // Number of input clocks in one core cycle for each mode level.
    localparam int unsigned SHORT_CYCLE = 2;
    localparam int unsigned LONG_CYCLE  = 3;

endpackage

// File: rtl/mmp_dual_core.sv
// Dual-ratio core: ends each core cycle after two input clocks when the mode
// input is high, or three when it is low.
// Assumes the mode input stays stable for a whole core cycle; it may change
// only on the edge that ends a cycle.
module mmp_dual_core
    import mmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_short,
    output logic       cycle_end,
    output logic [1:0] phase
);

    core_ph_t ph_q;

    // End the cycle on the second clock when short, otherwise on the third.
    always_comb begin
        cycle_end = ((ph_q == PH_SECOND) && mode_short) || (ph_q == PH_THIRD);
    end

    // Advance the phase and restart it when a core cycle ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_FIRST;
        end else if (cycle_end) begin
            ph_q <= PH_FIRST;
        end else if (ph_q == PH_FIRST) begin
            ph_q <= PH_SECOND;
        end else begin
            ph_q <= PH_THIRD;
        end
    end

    assign phase = ph_q;

endmodule

// File: rtl/mmp_chain.sv
// Binary chain of toggle stages that counts core cycles. Each stage toggles
// when all lower stages are one and a step arrives.
// Assumes step is a single-cycle pulse per core cycle.
module mmp_chain #(
    parameter int unsigned BITS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    output logic [BITS-1:0] count,
    output logic            at_last
);

    logic [BITS:0]   carry;
    logic [BITS-1:0] count_nxt;

    assign carry[0] = step;

    // One toggle stage per bit, each enabled by the carry from below.
    for (genvar i = 0; i < BITS; i++) begin : g_stage
        assign carry[i+1]   = carry[i] & count[i];
        assign count_nxt[i] = count[i] ^ carry[i];
    end

    // Register the whole chain in one place.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count_nxt;
        end
    end

    // Flag the final core cycle of an output period.
    assign at_last = &count;

endmodule

// File: rtl/mmp_mode_ctl.sv
// Mode steering: captures band and ratio choice at period end, forms the
// swallow NAND on the final core cycle and optionally inverts it.
// Assumes period_end is high for exactly one input clock per output period.
module mmp_mode_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic band_in,
    input  logic small_in,
    input  logic period_end,
    input  logic at_last,
    output logic mode_short,
    output logic band_q,
    output logic small_q
);

    logic swallow;
    logic nand_o;

    // Capture the controls only where one output period hands over to the next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            band_q  <= 1'b0;
            small_q <= 1'b0;
        end else if (period_end) begin
            band_q  <= band_in;
            small_q <= small_in;
        end
    end

    // Request one odd core cycle; the sense depends on the band so that a low
    // ratio input always picks the larger ratio.
    always_comb begin
        swallow = band_q ? small_q : ~small_q;
        nand_o  = ~(swallow & at_last);
    end

    // Upper band passes the inverted NAND output, lower band the direct one.
    always_comb begin
        mode_short = band_q ? ~nand_o : nand_o;
    end

endmodule

// File: rtl/mmp_divider.sv
// Top of the band-selectable multimodulus prescaler (32/33/47/48).
// Assumes clk_in is the only clock; band_hi and ratio_small are synchronous
// to it and are captured once per output period.
module mmp_divider #(
    parameter int unsigned CHAIN_BITS = 4
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic band_hi,
    input  logic ratio_small,
    output logic clk_div
);

    localparam int unsigned MSB = CHAIN_BITS - 1;

    logic                  mode_short;
    logic                  core_end;
    logic [1:0]            core_ph;
    logic [CHAIN_BITS-1:0] chain_cnt;
    logic                  chain_last;
    logic                  period_end;
    logic                  band_q;
    logic                  small_q;

    mmp_dual_core u_core (
        .clk        (clk_in),
        .rst_n      (rst_n),
        .mode_short (mode_short),
        .cycle_end  (core_end),
        .phase      (core_ph)
    );

    mmp_chain #(.BITS(CHAIN_BITS)) u_chain (
        .clk     (clk_in),
        .rst_n   (rst_n),
        .step    (core_end),
        .count   (chain_cnt),
        .at_last (chain_last)
    );

    // A period closes when the final core cycle of the chain ends.
    assign period_end = core_end & chain_last;

    mmp_mode_ctl u_ctl (
        .clk        (clk_in),
        .rst_n      (rst_n),
        .band_in    (band_hi),
        .small_in   (ratio_small),
        .period_end (period_end),
        .at_last    (chain_last),
        .mode_short (mode_short),
        .band_q     (band_q),
        .small_q    (small_q)
    );

    assign clk_div = chain_cnt[MSB];

endmodule

// File: rtl/mmp_divider_chk.sv
// Checker for mmp_divider: relates core phase, chain steps, captured controls
// and the output over time. Attached by bind below.
module mmp_divider_chk #(
    parameter int unsigned CHAIN_BITS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            ph,
    input logic                  core_end,
    input logic                  mode_short,
    input logic [CHAIN_BITS-1:0] cnt,
    input logic                  at_last,
    input logic                  band_q,
    input logic                  small_q,
    input logic                  clk_div
);

    // R1: reset clears chain, phase and output on the next edge.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0) && (ph == 2'd0) && !clk_div);

    // R9: the core phase never reaches an unused code.
    p_phase_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ph != 2'd3);

    // R9: no core cycle is shorter than two input clocks.
    p_min_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == 2'd0) |-> !core_end);

    // R9: away from the last core cycle the mode follows the band.
    p_base_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !at_last |-> (mode_short == !band_q));

    // R6: the chain advances by one on every core cycle end.
    p_chain_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        core_end |=> (cnt == CHAIN_BITS'($past(cnt) + 1'b1)));

    // R6: the chain holds between core cycle ends.
    p_chain_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !core_end |=> $stable(cnt));

    // R7: captured controls change only where a period ends.
    p_ctl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_end && at_last) |=> ($stable(band_q) && $stable(small_q)));

endmodule

bind mmp_divider mmp_divider_chk #(.CHAIN_BITS(CHAIN_BITS)) u_chk (
    .clk        (clk_in),
    .rst_n      (rst_n),
    .ph         (core_ph),
    .core_end   (core_end),
    .mode_short (mode_short),
    .cnt        (chain_cnt),
    .at_last    (chain_last),
    .band_q     (band_q),
    .small_q    (small_q),
    .clk_div    (clk_div)
);

// File: tb/mmp_divider_test.sv
module mmp_divider_test;

    localparam int CLK_PERIOD = 10;
    localparam int CHAIN_BITS = 4;
    localparam int CORE_CYC   = 1 << CHAIN_BITS;

    logic clk_in      = 1'b0;
    logic rst_n       = 1'b0;
    logic band_hi     = 1'b0;
    logic ratio_small = 1'b0;
    logic clk_div;

    int checks   = 0;
    int errors   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk_in = ~clk_in;

    mmp_divider #(.CHAIN_BITS(CHAIN_BITS)) uut (
        .clk_in      (clk_in),
        .rst_n       (rst_n),
        .band_hi     (band_hi),
        .ratio_small (ratio_small),
        .clk_div     (clk_div)
    );

    // Expected period from the requirements: base cycle times chain length,
    // plus one for 33, minus one for 47.
    function automatic int exp_total(bit b, bit s);
        int base;
        base = b ? 3 : 2;
        if (!b && !s) return base * CORE_CYC + 1;
        if (b && s)   return base * CORE_CYC - 1;
        return base * CORE_CYC;
    endfunction

    // High time: the last half of the core cycles, including the odd one.
    function automatic int exp_high(bit b, bit s);
        return exp_total(b, s) - (b ? 3 : 2) * (CORE_CYC / 2);
    endfunction

    function automatic string ratio_tag(bit b, bit s);
        if (!b && s)  return "R2";
        if (!b && !s) return "R3";
        if (b && s)   return "R4";
        return "R5";
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Count input cycles (at falling clock edges) up to the next falling edge
    // of clk_div, and the cycles in that window with clk_div high.
    task automatic measure(output int total, output int high);
        logic prev;
        bit   done;
        total = 0;
        high  = 0;
        prev  = clk_div;
        done  = 1'b0;
        while (!done) begin
            @(negedge clk_in);
            total++;
            if (clk_div) high++;
            if (prev === 1'b1 && clk_div === 1'b0) done = 1'b1;
            prev = clk_div;
        end
    endtask

    task automatic check_period(input string tag, input bit b, input bit s);
        int t;
        int h;
        measure(t, h);
        check(tag, "period", t, exp_total(b, s));
        check("R6", "high time", h, exp_high(b, s));
        check("R9", "low time", t - h, (b ? 3 : 2) * (CORE_CYC / 2));
    endtask

    initial begin
        int t;
        int h;
        // R1: output low while reset is held.
        band_hi     = 1'b1;
        ratio_small = 1'b1;
        rst_n       = 1'b0;
        repeat (4) @(negedge clk_in);
        check("R1", "clk_div in reset", int'(clk_div), 0);

        // R8: first period after release is 33 regardless of inputs.
        rst_n = 1'b1;
        measure(t, h);
        check("R8", "first period", t, 33);
        check("R8", "first high time", h, 17);

        // Inputs held through the first period take effect now: 47.
        check_period("R4", 1'b1, 1'b1);

        // Sweep every ordered pair of settings.
        for (int from = 0; from < 4; from++) begin
            for (int to = 0; to < 4; to++) begin
                band_hi     = from[1];
                ratio_small = from[0];
                measure(t, h);
                check_period(ratio_tag(from[1], from[0]), from[1], from[0]);
                band_hi     = to[1];
                ratio_small = to[0];
                // R7: the period in progress keeps the old ratio.
                check_period("R7", from[1], from[0]);
                // R7: the following period uses the new ratio.
                check_period(ratio_tag(to[1], to[0]), to[1], to[0]);
            end
        end

        // R1: reset applied while clk_div is high forces it low.
        while (clk_div !== 1'b1) @(negedge clk_in);
        rst_n = 1'b0;
        @(negedge clk_in);
        check("R1", "clk_div after mid-run reset", int'(clk_div), 0);
        repeat (3) @(negedge clk_in);
        check("R1", "clk_div held in reset", int'(clk_div), 0);

        // R8: restart gives 33 again even with 48 requested.
        band_hi     = 1'b1;
        ratio_small = 1'b0;
        rst_n       = 1'b1;
        measure(t, h);
        check("R8", "first period after second reset", t, 33);
        check_period("R5", 1'b1, 1'b0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule